// File: doc/BRIEF.md
# NAND Strobe Timing Generator

This block turns single-byte transfer requests into correctly timed NAND bus activity. It drives the write and read strobes, the command and address latch enables, the chip enable and the byte-wide data output. It samples the ready/busy line. Every phase length comes from one packed timing word, so the same hardware serves any clock rate. Software loads that word with cycle counts computed from the bus clock.

Three configuration registers sit behind a key-guarded lock: the timing word, the interface configuration (large-block and four-address-cycle flags passed to the neighbouring sequencer) and the chip-enable mode. A request port accepts a command byte, an address byte, a data byte to write, or a data byte to read. It reports completion with a one-cycle pulse.

The controller is a Moore machine with these states:
- **IDLE**: waits for a request.
- **CEA**: chip-enable access delay.
- **WLOW / WHIGH**: write strobe low and high phases.
- **BUSY**: post-command busy delay.
- **RBWAIT**: waits for the ready line.
- **TURN**: write-to-read turnaround.
- **RLOW / RHIGH**: read strobe low and high phases.
- **FIN**: completion cycle.

The transitions are:
- IDLE→CEA on a request when normal CE mode is selected and the access count is non-zero; otherwise IDLE goes straight to the first strobe state.
- The first strobe state is WLOW for command, address and write data. For a read it is TURN when the last strobe was a write and turnaround is non-zero; otherwise it is RLOW.
- CEA→first strobe state.
- WLOW→WHIGH.
- WHIGH→BUSY for a command with a non-zero busy count; WHIGH→RBWAIT for a command with a zero busy count; WHIGH→FIN otherwise.
- BUSY→RBWAIT.
- RBWAIT→FIN once the ready line reads high.
- TURN→RLOW.
- RLOW→RHIGH.
- RHIGH→FIN.
- FIN→IDLE.

Top module: `nand_strobe_gen`

## Requirements
- R1: After reset the bus is idle: CE# high, WE# and RE# high, CLE, ALE and io_oe low, io_o zero. req_ready is 1, xfer_done is 0. The timing word holds its parameter default, both interface flags are 0, and the lock is closed.
- R2: Writes to the interface, timing and CE-mode registers take effect only while the lock is open. Writing 0xA25E to bits 15:0 of the lock register (selector 0) opens it. Writing any other value to the lock register closes it. Any write to a protected register closes it again, and while the lock is closed such a write changes nothing.
- R3: The timing register (selector 2) packs its fields as follows:
  - write-low: bits 3:0
  - write-high: bits 7:4
  - read-low: bits 11:8
  - read-high: bits 15:12
  - turnaround: bits 18:16
  - busy delay: bits 23:19
  - CE-access: bits 25:24

  It reads back on cfg_timing.
- R4: A write-type transfer holds WE# low for the write-low count of cycles, then high for the write-high count, with io_oe=1 and io_o equal to the request byte throughout both phases. A zero strobe count means one cycle.
- R5: req_kind selects the transfer type: 0 command, 1 address, 2 write data, 3 read data. CLE is high only during the strobe phases of a command, and ALE only during those of an address.
- R6: In normal CE mode, CE# goes low for the CE-access count of cycles before the first strobe phase (none when the count is 0). It stays low to the end of the last phase and returns high in the completion cycle.
- R7: Selector 3 bit 0 sets the CE mode: 1 (reset value) selects normal operation, 0 forces CE# low at all times. When CE# is forced low, no CE-access delay is inserted.
- R8: After a command's write strobe, the busy-delay count of cycles elapses with the ready line ignored. The block then waits until nand_rb_n reads 1 before completing.
- R9: A read whose previous strobe was a write starts with the turnaround count of idle cycles. A read following a read starts without them.
- R10: A read holds RE# low for the read-low count, then high for the read-high count, with io_oe=0. rd_data takes nand_io_i as sampled in the last read-low cycle and holds it until the next read.
- R11: xfer_done pulses for exactly one cycle after the last phase, then req_ready returns. While req_ready is 0, requests are ignored, including any change of the request byte.
- R12: The interface register (selector 1) drives cfg_large_blk from bit 2 and cfg_addr4 from bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 lock, 1 interface, 2 timing, 3 CE mode |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Transfer request |
| req_kind | input | 2 | Transfer type |
| req_byte | input | 8 | Byte to send |
| req_ready | output | 1 | Idle, request accepted this cycle |
| xfer_done | output | 1 | Completion pulse |
| rd_data | output | 8 | Last byte read |
| cfg_large_blk | output | 1 | Large-block flag |
| cfg_addr4 | output | 1 | Four-address-cycle flag |
| cfg_timing | output | 26 | Current timing word |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_o | output | 8 | Data bus out |
| nand_io_oe | output | 1 | Data bus drive enable |
| nand_io_i | input | 8 | Data bus in |
| nand_rb_n | input | 1 | Ready/busy, low while busy |

## Verification
Two delays can coincide with another function.
- **Ready line during the busy delay.** The ready line can already be high while the busy delay is still running. The bench provokes this by issuing commands with the ready line never low and with it held low past the delay. It judges that the completion cycle arrives only after both the full busy count and the first high sample.
- **Access delay before a read after a write.** The CE-access delay and the turnaround both fall in front of the same read strobe. The bench issues a read directly after a write, with both counts non-zero. It requires the access cycles first, the turnaround cycles next, and the read strobe after that.

The reference model predicts every pin on every cycle, so an extra or missing cycle in either case shows as a miscompare.

// File: rtl/nand_tim_pkg.sv
package nand_tim_pkg;

    localparam logic [15:0] UNLOCK_KEY = 16'hA25E;

    localparam logic [1:0] SEL_LOCK  = 2'd0;
    localparam logic [1:0] SEL_IFACE = 2'd1;
    localparam logic [1:0] SEL_TIME  = 2'd2;
    localparam logic [1:0] SEL_CEMOD = 2'd3;

    localparam int TWORD_W = 26;

    typedef struct packed {
        logic [1:0] cea;
        logic [4:0] busy;
        logic [2:0] turn;
        logic [3:0] rh;
        logic [3:0] rl;
        logic [3:0] wh;
        logic [3:0] wl;
    } tword_t;

    typedef enum logic [1:0] {
        XK_CMD   = 2'd0,
        XK_ADDR  = 2'd1,
        XK_WDATA = 2'd2,
        XK_RDATA = 2'd3
    } xkind_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CEA,
        ST_WLOW,
        ST_WHIGH,
        ST_BUSY,
        ST_RBWAIT,
        ST_TURN,
        ST_RLOW,
        ST_RHIGH,
        ST_FIN
    } nst_t;

endpackage

// File: rtl/nand_cfg_bank.sv
module nand_cfg_bank
    import nand_tim_pkg::*;
#(
    parameter logic [TWORD_W-1:0] TIM_INIT = '0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [1:0]  sel,
    input  logic [31:0] wdata,
    output tword_t      tim,
    output logic        large_blk,
    output logic        addr4,
    output logic        ce_normal,
    output logic        open_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q    <= 1'b0;
            tim       <= tword_t'(TIM_INIT);
            large_blk <= 1'b0;
            addr4     <= 1'b0;
            ce_normal <= 1'b1;
        end else if (we) begin
            unique case (sel)
                SEL_LOCK: begin
                    open_q <= (wdata[15:0] == UNLOCK_KEY);
                end
                SEL_IFACE: begin
                    if (open_q) begin
                        large_blk <= wdata[2];
                        addr4     <= wdata[1];
                        open_q    <= 1'b0;
                    end
                end
                SEL_TIME: begin
                    if (open_q) begin
                        tim    <= tword_t'(wdata[TWORD_W-1:0]);
                        open_q <= 1'b0;
                    end
                end
                SEL_CEMOD: begin
                    if (open_q) begin
                        ce_normal <= wdata[0];
                        open_q    <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/nand_xfer_fsm.sv
module nand_xfer_fsm
    import nand_tim_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tword_t        tim,
    input  logic          ce_normal,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [DW-1:0] req_byte,
    input  logic [DW-1:0] io_i,
    input  logic          rb_n,
    output logic          req_ready,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic          ce_n,
    output logic          cle,
    output logic          ale,
    output logic          we_n,
    output logic          re_n,
    output logic [DW-1:0] io_o,
    output logic          io_oe
);

    nst_t          st, st_n;
    logic [CW-1:0] cnt, cnt_n;
    xkind_t        kind_q, k_eff;
    logic [DW-1:0] byte_q;
    logic          wr_last;
    nst_t          first_st;
    logic [CW-1:0] first_cnt;
    logic          last_cyc;

    function automatic logic [CW-1:0] strobe_m1(input logic [3:0] v);
        return (v == 4'd0) ? '0 : CW'(v) - CW'(1);
    endfunction

    assign last_cyc = (cnt == '0);

    always_comb begin
        k_eff = (st == ST_IDLE) ? xkind_t'(req_kind) : kind_q;
        if (k_eff == XK_RDATA) begin
            if (wr_last && (tim.turn != 3'd0)) begin
                first_st  = ST_TURN;
                first_cnt = CW'(tim.turn) - CW'(1);
            end else begin
                first_st  = ST_RLOW;
                first_cnt = strobe_m1(tim.rl);
            end
        end else begin
            first_st  = ST_WLOW;
            first_cnt = strobe_m1(tim.wl);
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = (cnt == '0) ? '0 : cnt - CW'(1);
        unique case (st)
            ST_IDLE: begin
                cnt_n = '0;
                if (req_valid) begin
                    if (ce_normal && (tim.cea != 2'd0)) begin
                        st_n  = ST_CEA;
                        cnt_n = CW'(tim.cea) - CW'(1);
                    end else begin
                        st_n  = first_st;
                        cnt_n = first_cnt;
                    end
                end
            end
            ST_CEA: if (last_cyc) begin
                st_n  = first_st;
                cnt_n = first_cnt;
            end
            ST_WLOW: if (last_cyc) begin
                st_n  = ST_WHIGH;
                cnt_n = strobe_m1(tim.wh);
            end
            ST_WHIGH: if (last_cyc) begin
                if (kind_q == XK_CMD) begin
                    if (tim.busy != 5'd0) begin
                        st_n  = ST_BUSY;
                        cnt_n = CW'(tim.busy) - CW'(1);
                    end else begin
                        st_n = ST_RBWAIT;
                    end
                end else begin
                    st_n = ST_FIN;
                end
            end
            ST_BUSY:   if (last_cyc) st_n = ST_RBWAIT;
            ST_RBWAIT: if (rb_n) st_n = ST_FIN;
            ST_TURN: if (last_cyc) begin
                st_n  = ST_RLOW;
                cnt_n = strobe_m1(tim.rl);
            end
            ST_RLOW: if (last_cyc) begin
                st_n  = ST_RHIGH;
                cnt_n = strobe_m1(tim.rh);
            end
            ST_RHIGH: if (last_cyc) st_n = ST_FIN;
            ST_FIN:   st_n = ST_IDLE;
            default:  st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            kind_q  <= XK_CMD;
            byte_q  <= '0;
            wr_last <= 1'b0;
            rd_data <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            if ((st == ST_IDLE) && req_valid) begin
                kind_q <= xkind_t'(req_kind);
                byte_q <= req_byte;
            end
            if ((st == ST_WHIGH) && last_cyc) wr_last <= 1'b1;
            if ((st == ST_RLOW) && last_cyc) begin
                wr_last <= 1'b0;
                rd_data <= io_i;
            end
        end
    end

    always_comb begin
        req_ready = 1'b0;
        done      = 1'b0;
        ce_n      = 1'b0;
        cle       = 1'b0;
        ale       = 1'b0;
        we_n      = 1'b1;
        re_n      = 1'b1;
        io_oe     = 1'b0;
        io_o      = '0;
        unique case (st)
            ST_IDLE: begin
                req_ready = 1'b1;
                ce_n      = ce_normal;
            end
            ST_FIN: begin
                done = 1'b1;
                ce_n = ce_normal;
            end
            ST_WLOW, ST_WHIGH: begin
                we_n  = (st != ST_WLOW);
                cle   = (kind_q == XK_CMD);
                ale   = (kind_q == XK_ADDR);
                io_oe = 1'b1;
                io_o  = byte_q;
            end
            ST_RLOW: re_n = 1'b0;
            default: ;
        endcase
    end

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
    import nand_tim_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 5,
    parameter logic [TWORD_W-1:0] TIM_INIT = TWORD_W'((1 << 24) | (2 << 19) | (1 << 16) | (1 << 12) | (1 << 8) | (1 << 4) | 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [31:0]        cfg_wdata,
    input  logic               req_valid,
    input  logic [1:0]         req_kind,
    input  logic [DW-1:0]      req_byte,
    output logic               req_ready,
    output logic               xfer_done,
    output logic [DW-1:0]      rd_data,
    output logic               cfg_large_blk,
    output logic               cfg_addr4,
    output logic [TWORD_W-1:0] cfg_timing,
    output logic               nand_ce_n,
    output logic               nand_cle,
    output logic               nand_ale,
    output logic               nand_we_n,
    output logic               nand_re_n,
    output logic [DW-1:0]      nand_io_o,
    output logic               nand_io_oe,
    input  logic [DW-1:0]      nand_io_i,
    input  logic               nand_rb_n
);

    tword_t tim;
    logic   ce_normal;
    logic   cfg_open;

    nand_cfg_bank #(.TIM_INIT(TIM_INIT)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .sel       (cfg_sel),
        .wdata     (cfg_wdata),
        .tim       (tim),
        .large_blk (cfg_large_blk),
        .addr4     (cfg_addr4),
        .ce_normal (ce_normal),
        .open_q    (cfg_open)
    );

    assign cfg_timing = tim;

    nand_xfer_fsm #(.DW(DW), .CW(CW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tim       (tim),
        .ce_normal (ce_normal),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_byte  (req_byte),
        .io_i      (nand_io_i),
        .rb_n      (nand_rb_n),
        .req_ready (req_ready),
        .done      (xfer_done),
        .rd_data   (rd_data),
        .ce_n      (nand_ce_n),
        .cle       (nand_cle),
        .ale       (nand_ale),
        .we_n      (nand_we_n),
        .re_n      (nand_re_n),
        .io_o      (nand_io_o),
        .io_oe     (nand_io_oe)
    );

endmodule

// File: rtl/nand_tim_chk.sv
module nand_tim_chk
    import nand_tim_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               we_n,
    input logic               re_n,
    input logic               ce_n,
    input logic               cle,
    input logic               ale,
    input logic               io_oe,
    input logic               done,
    input logic               ready,
    input logic               cfg_we,
    input logic [1:0]         cfg_sel,
    input logic               cfg_open,
    input logic [TWORD_W-1:0] cfg_timing
);

    a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    a_r6_ce_covers_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> !ce_n);

    a_r5_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    a_r10_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !io_oe);

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_done_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && ready));

    a_r2_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_sel == SEL_TIME) && !cfg_open) |=> $stable(cfg_timing));

    a_r2_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_sel != SEL_LOCK) && cfg_open) |=> !cfg_open);

endmodule

bind nand_strobe_gen nand_tim_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_n       (nand_we_n),
    .re_n       (nand_re_n),
    .ce_n       (nand_ce_n),
    .cle        (nand_cle),
    .ale        (nand_ale),
    .io_oe      (nand_io_oe),
    .done       (xfer_done),
    .ready      (req_ready),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_open   (cfg_open),
    .cfg_timing (cfg_timing)
);

// File: tb/sim_nand_strobe_gen.sv
module sim_nand_strobe_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [7:0]  req_byte = '0;
    logic        req_ready, xfer_done;
    logic [7:0]  rd_data;
    logic        cfg_large_blk, cfg_addr4;
    logic [25:0] cfg_timing;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]  nand_io_o;
    logic [7:0]  nand_io_i = '0;
    logic        nand_rb_n = 1'b1;

    nand_strobe_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_kind(req_kind), .req_byte(req_byte),
        .req_ready(req_ready), .xfer_done(xfer_done), .rd_data(rd_data),
        .cfg_large_blk(cfg_large_blk), .cfg_addr4(cfg_addr4), .cfg_timing(cfg_timing),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_o(nand_io_o),
        .nand_io_oe(nand_io_oe), .nand_io_i(nand_io_i), .nand_rb_n(nand_rb_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model state
    int m_wl = 1, m_wh = 1, m_rl = 1, m_rh = 1, m_turn = 1, m_busy = 2, m_cea = 1;
    bit m_norm = 1'b1, m_open = 1'b0, m_lastw = 1'b0, m_large = 1'b0, m_addr4 = 1'b0;
    logic [7:0] m_rd = 8'h00;
    logic [15:0] expq[$];
    int n_chk = 0, n_bad = 0;

    function automatic logic [31:0] tword(int cea, int busy, int turn, int rh, int rl, int wh, int wl);
        return (cea << 24) | (busy << 19) | (turn << 16) | (rh << 12) | (rl << 8) | (wh << 4) | wl;
    endfunction

    function automatic int slen(int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic [15:0] pins(bit ce, bit cl, bit al, bit we, bit re, bit oe,
                                         logic [7:0] io, bit dn, bit rdy);
        return {ce, cl, al, we, re, oe, io, dn, rdy};
    endfunction

    task automatic push(int n, logic [15:0] v);
        for (int i = 0; i < n; i++) expq.push_back(v);
    endtask

    task automatic check_now(string tag);
        logic [15:0] e, g;
        e = (expq.size() > 0) ? expq.pop_front()
                              : pins(m_norm, 0, 0, 1, 1, 0, 8'h00, 0, 1);
        g = {nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe,
             nand_io_o, xfer_done, req_ready};
        n_chk++;
        if (g !== e) begin
            n_bad++;
            $display("FAIL %s pins got %h exp %h at %0t", tag, g, e, $time);
        end
    endtask

    task automatic step(string tag);
        @(negedge clk);
        check_now(tag);
    endtask

    task automatic chk_val(string tag, logic [31:0] g, logic [31:0] e);
        n_chk++;
        if (g !== e) begin
            n_bad++;
            $display("FAIL %s value got %h exp %h", tag, g, e);
        end
    endtask

    task automatic cfg_wr(logic [1:0] sel, logic [31:0] d, string tag);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        case (sel)
            2'd0: m_open = (d[15:0] == 16'hA25E);
            2'd1: if (m_open) begin m_large = d[2]; m_addr4 = d[1]; m_open = 0; end
            2'd2: if (m_open) begin
                      m_wl = d[3:0]; m_wh = d[7:4]; m_rl = d[11:8]; m_rh = d[15:12];
                      m_turn = d[18:16]; m_busy = d[23:19]; m_cea = d[25:24]; m_open = 0;
                  end
            default: if (m_open) begin m_norm = d[0]; m_open = 0; end
        endcase
        step(tag);
        cfg_we = 1'b0;
    endtask

    task automatic chk_cfg(string tag);
        chk_val(tag, {6'd0, cfg_timing},
                tword(m_cea, m_busy, m_turn, m_rh, m_rl, m_wh, m_wl));
        chk_val(tag, {30'd0, cfg_large_blk, cfg_addr4}, {30'd0, m_large, m_addr4});
    endtask

    // kind: 0 cmd, 1 addr, 2 wdata, 3 rdata
    task automatic xfer(int kind, logic [7:0] b, int rbl, bit hold, logic [7:0] rdv, string tag);
        int idx;
        bit cl, al;
        int e, rbw;
        req_valid = 1'b1; req_kind = 2'(kind); req_byte = b;
        nand_io_i = rdv;
        nand_rb_n = (rbl > 0) ? 1'b0 : 1'b1;
        cl = (kind == 0); al = (kind == 1);
        if (m_norm && m_cea > 0) push(m_cea, pins(0, 0, 0, 1, 1, 0, 8'h00, 0, 0));
        if (kind == 3) begin
            if (m_lastw && m_turn > 0) push(m_turn, pins(0, 0, 0, 1, 1, 0, 8'h00, 0, 0));
            push(slen(m_rl), pins(0, 0, 0, 1, 0, 0, 8'h00, 0, 0));
            push(slen(m_rh), pins(0, 0, 0, 1, 1, 0, 8'h00, 0, 0));
            m_lastw = 0;
            m_rd = rdv;
        end else begin
            push(slen(m_wl), pins(0, cl, al, 0, 1, 1, b, 0, 0));
            push(slen(m_wh), pins(0, cl, al, 1, 1, 1, b, 0, 0));
            if (kind == 0) begin
                push(m_busy, pins(0, 0, 0, 1, 1, 0, 8'h00, 0, 0));
                e = expq.size();
                rbw = (rbl > e) ? (rbl - e + 1) : 1;
                push(rbw, pins(0, 0, 0, 1, 1, 0, 8'h00, 0, 0));
            end
            m_lastw = 1;
        end
        push(1, pins(m_norm, 0, 0, 1, 1, 0, 8'h00, 1, 0));
        idx = 0;
        while (expq.size() > 0) begin
            step(tag);
            req_valid = hold && (expq.size() > 1);
            if (hold) req_byte = ~b;
            nand_rb_n = (idx >= rbl);
            idx++;
        end
        req_valid = 1'b0;
        nand_rb_n = 1'b1;
        chk_val(tag, {24'd0, rd_data}, {24'd0, m_rd});
        step(tag);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL R11 watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step("R1");
        chk_cfg("R1");

        // R2: protected writes ignored while locked
        cfg_wr(2'd2, tword(3, 7, 5, 9, 9, 9, 9), "R2");
        chk_cfg("R2");
        cfg_wr(2'd0, 32'h0000_A25F, "R2");
        cfg_wr(2'd2, tword(3, 7, 5, 9, 9, 9, 9), "R2");
        chk_cfg("R2");

        // R3: unlock and load distinct field values
        cfg_wr(2'd0, 32'h0000_A25E, "R3");
        cfg_wr(2'd2, tword(2, 3, 2, 3, 4, 2, 3), "R3");
        chk_cfg("R3");

        // R2: lock re-armed, interface write ignored; R12 after unlocking
        cfg_wr(2'd1, 32'h6, "R2");
        chk_cfg("R2");
        cfg_wr(2'd0, 32'hFFFF_A25E, "R12");
        cfg_wr(2'd1, 32'h4, "R12");
        chk_cfg("R12");
        cfg_wr(2'd0, 32'h0000_A25E, "R12");
        cfg_wr(2'd1, 32'h2, "R12");
        chk_cfg("R12");

        // R5, R8: command with ready already high, busy delay still applies
        xfer(0, 8'h70, 0, 0, 8'h00, "R8");
        // R5: address byte with ALE
        xfer(1, 8'h3C, 0, 0, 8'h00, "R5");
        // R4, R6: data write with CE access delay
        xfer(2, 8'hA5, 0, 0, 8'h00, "R4");
        // R9, R10: read after write gets turnaround
        xfer(3, 8'h00, 0, 0, 8'h5A, "R9");
        // R10: read after read has no turnaround
        xfer(3, 8'h00, 0, 0, 8'hC3, "R10");
        // R8: command with ready held low past the busy delay
        xfer(0, 8'h30, 20, 0, 8'h00, "R8");
        // R11: request held and byte changed while busy
        xfer(2, 8'h96, 0, 1, 8'h00, "R11");

        // R4, R6: zero counts give single-cycle strobes, no delays
        cfg_wr(2'd0, 32'h0000_A25E, "R6");
        cfg_wr(2'd2, tword(0, 0, 0, 0, 0, 0, 0), "R6");
        chk_cfg("R6");
        xfer(2, 8'h11, 0, 0, 8'h00, "R4");
        xfer(3, 8'h00, 0, 0, 8'h22, "R9");
        xfer(0, 8'hFF, 3, 0, 8'h00, "R8");

        // R7: forced chip enable, access delay skipped
        cfg_wr(2'd0, 32'h0000_A25E, "R7");
        cfg_wr(2'd2, tword(3, 1, 1, 2, 2, 2, 2), "R7");
        cfg_wr(2'd0, 32'h0000_A25E, "R7");
        cfg_wr(2'd3, 32'h0, "R7");
        step("R7");
        xfer(1, 8'h0F, 0, 0, 8'h00, "R7");
        xfer(3, 8'h00, 0, 0, 8'h81, "R7");

        // R6: back to normal CE mode, access delay returns
        cfg_wr(2'd0, 32'h0000_A25E, "R6");
        cfg_wr(2'd3, 32'h1, "R6");
        xfer(2, 8'h44, 0, 0, 8'h00, "R6");

        repeat (3) step("R11");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule